// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block brings one DDR3 channel from power-on to a usable state after a single start strobe. It drives the memory reset pin and the clock-enable pin through their required settling intervals. It then issues the mode-register writes for each chip select that must be programmed. It closes with two long ZQ calibration commands. Commands leave the block as a one-cycle strobe that carries a command type, a bank address, a 13-bit address word and a chip-select index. A command encoder downstream turns that strobe into pin activity.

Every interval is set in nanoseconds and turned into a clock count at elaboration time. The count is rounded up against the clock-period parameter. Each mode-register word is built from fixed fields and two live inputs: a 3-bit nominal termination code and a 2-bit dynamic write-termination code. Chip selects come from a presence mask and are visited from the lowest index upward. Every present chip select is programmed when a registered module is fitted. Otherwise only the first present one is programmed.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: After reset, mem_rst_n, cke, busy, done and cmd_vld are all 0.
- R2: On the clock edge that samples start while the block is idle, busy goes to 1 and mem_rst_n is driven 0. mem_rst_n rises RST_CYC cycles after that edge. cke rises STB_CYC cycles after that. The first command appears CKE_CYC+1 cycles after cke rises. Each count is ceil(T_ns*1000/CLK_PS).
- R3: For each chip select, four MRS commands (cmd_type 0) are issued with banks 2, 3, 1 and 0 in that order. They are spaced exactly TMRD_CYC cycles apart, and each cmd_vld lasts one cycle.
- R4: The bank-0 word is 13'h528: burst-type bit 3, value 2 in bits 6:4, DLL-reset bit 8 and value 2 in bits 11:9.
- R5: The bank-1 word has bit 1 set. Termination code bits 0, 1 and 2 appear at address bits 2, 6 and 9. All other bits are 0.
- R6: The bank-2 word has bit 6 set and the dynamic code in bits 10:9. All other bits, including 5:3, are 0.
- R7: The bank-3 word is zero.
- R8: Chip selects are visited in ascending order, and those with a clear mask bit are skipped. The next chip select's first command comes DLL_CYC+1 cycles after the previous bank-0 command. With rdimm at 0, only the lowest present chip select is programmed.
- R9: The last bank-0 command is followed DLL_CYC+1 cycles later by a ZQCL command: cmd_type 1, bank 0, address 13'h400, chip select 0. A second ZQCL to chip select 1 follows TZQ_CYC+1 cycles after the first. TZQ_CYC cycles after the second, done pulses for one cycle and busy falls on the same edge.
- R10: A start strobe while busy changes neither the timing nor the contents of the sequence.
- R11: With an all-zero mask, no MRS is issued and the first ZQCL appears CKE_CYC+1 cycles after cke rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the sequence (ignored while busy) |
| cs_mask | input | NUM_CS | Chip-select presence mask |
| rdimm | input | 1 | Registered module fitted |
| odt_nom | input | 3 | Nominal termination code |
| odt_dyn | input | 2 | Dynamic write-termination code |
| mem_rst_n | output | 1 | Memory reset pin, active low |
| cke | output | 1 | Memory clock enable |
| cmd_vld | output | 1 | One-cycle command strobe |
| cmd_type | output | 1 | 0 = MRS, 1 = ZQCL |
| cmd_ba | output | 3 | Bank address |
| cmd_addr | output | 13 | Address word |
| cmd_cs | output | CS_W | Chip-select index |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every result is timed from the edge that samples start, called offset 0:
- mem_rst_n rises at offset RST_CYC.
- cke rises at offset RST_CYC+STB_CYC.
- The first command comes CKE_CYC+1 cycles after that.
- Later commands, the ZQCL pair and done follow at the fixed gaps set by R3, R8 and R9.

The driver works out each expected command, together with the offset at which it is due, from these rules and the chosen inputs, and queues it. A monitor samples on the falling clock edge and turns the cycle count into an offset. Every strobe it sees must match the head of the queue in both offset and content. The pin edges and done are checked against their own computed offsets in the same way.

// File: rtl/ddr3_pwrup_seq.sv
module ddr3_pwrup_seq #(
  parameter int CLK_PS      = 2500,
  parameter int T_RESET_NS  = 200000,
  parameter int T_STAB_NS   = 500000,
  parameter int T_CKE_NS    = 360,
  parameter int T_DLL_NS    = 500000,
  parameter int TMRD_CYC    = 4,
  parameter int TZQINIT_CYC = 512,
  parameter int NUM_CS      = 8,
  localparam int CS_W       = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NUM_CS-1:0] cs_mask,
  input  logic              rdimm,
  input  logic [2:0]        odt_nom,
  input  logic [1:0]        odt_dyn,
  output logic              mem_rst_n,
  output logic              cke,
  output logic              cmd_vld,
  output logic              cmd_type,
  output logic [2:0]        cmd_ba,
  output logic [12:0]       cmd_addr,
  output logic [CS_W-1:0]   cmd_cs,
  output logic              busy,
  output logic              done
);
  localparam int RST_CYC = (T_RESET_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int STB_CYC = (T_STAB_NS  * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int CKE_CYC = (T_CKE_NS   * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int DLL_CYC = (T_DLL_NS   * 1000 + CLK_PS - 1) / CLK_PS;

  typedef enum logic [2:0] {S_IDLE, S_RST, S_STAB, S_CKEW, S_MRS, S_DLLW, S_ZQ, S_ZQW} st_t;

  st_t             st;
  logic [31:0]     cnt;
  logic [1:0]      step;
  logic [CS_W-1:0] cs_q;
  logic            zq_odd;
  logic            cnt_z;
  logic [CS_W-1:0] first_cs, nxt_cs;
  logic            first_ok, nxt_ok;
  logic [12:0]     mr_word;
  logic [2:0]      mr_bank;

  assign cnt_z = (cnt == 32'd0);

  always_comb begin
    first_cs = '0; first_ok = 1'b0;
    nxt_cs   = '0; nxt_ok   = 1'b0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (cs_mask[i]) begin
        first_cs = CS_W'(i); first_ok = 1'b1;
        if (i > int'(cs_q)) begin
          nxt_cs = CS_W'(i); nxt_ok = 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (step)
      2'd0:    begin mr_bank = 3'd2; mr_word = {2'b00, odt_dyn, 9'h040}; end
      2'd1:    begin mr_bank = 3'd3; mr_word = 13'h000; end
      2'd2:    begin mr_bank = 3'd1;
                 mr_word = {3'b000, odt_nom[2], 2'b00, odt_nom[1], 3'b000, odt_nom[0], 2'b10}; end
      default: begin mr_bank = 3'd0; mr_word = 13'h528; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; step <= '0; cs_q <= '0; zq_odd <= 1'b0;
      mem_rst_n <= 1'b0; cke <= 1'b0; busy <= 1'b0; done <= 1'b0;
      cmd_vld <= 1'b0; cmd_type <= 1'b0; cmd_ba <= '0; cmd_addr <= '0; cmd_cs <= '0;
    end else begin
      cmd_vld <= 1'b0;
      done    <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_RST; cnt <= 32'(RST_CYC - 1);
          busy <= 1'b1; mem_rst_n <= 1'b0; cke <= 1'b0;
        end
        S_RST: if (cnt_z) begin
          st <= S_STAB; cnt <= 32'(STB_CYC - 1); mem_rst_n <= 1'b1;
        end else cnt <= cnt - 1;
        S_STAB: if (cnt_z) begin
          st <= S_CKEW; cnt <= 32'(CKE_CYC - 1); cke <= 1'b1;
        end else cnt <= cnt - 1;
        S_CKEW: if (cnt_z) begin
          step <= '0; zq_odd <= 1'b0; cs_q <= first_cs;
          st <= first_ok ? S_MRS : S_ZQ;
        end else cnt <= cnt - 1;
        S_MRS: if (cnt_z) begin
          cmd_vld <= 1'b1; cmd_type <= 1'b0; cmd_ba <= mr_bank;
          cmd_addr <= mr_word; cmd_cs <= cs_q;
          if (step == 2'd3) begin
            st <= S_DLLW; cnt <= 32'(DLL_CYC - 1);
          end else begin
            step <= step + 1'b1; cnt <= 32'(TMRD_CYC - 1);
          end
        end else cnt <= cnt - 1;
        S_DLLW: if (cnt_z) begin
          step <= '0;
          if (rdimm && nxt_ok) begin
            cs_q <= nxt_cs; st <= S_MRS;
          end else st <= S_ZQ;
        end else cnt <= cnt - 1;
        S_ZQ: begin
          cmd_vld <= 1'b1; cmd_type <= 1'b1; cmd_ba <= 3'd0;
          cmd_addr <= 13'h400; cmd_cs <= CS_W'(zq_odd);
          st <= S_ZQW; cnt <= 32'(TZQINIT_CYC - 1);
        end
        S_ZQW: if (cnt_z) begin
          if (!zq_odd) begin
            zq_odd <= 1'b1; st <= S_ZQ;
          end else begin
            done <= 1'b1; busy <= 1'b0; st <= S_IDLE;
          end
        end else cnt <= cnt - 1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ddr3_pwrup_seq_chk.sv
module ddr3_pwrup_seq_chk #(
  parameter int NUM_CS = 8,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [NUM_CS-1:0] cs_mask,
  input logic              mem_rst_n,
  input logic              cke,
  input logic              cmd_vld,
  input logic              cmd_type,
  input logic [2:0]        cmd_ba,
  input logic [12:0]       cmd_addr,
  input logic [CS_W-1:0]   cmd_cs,
  input logic              busy,
  input logic              done
);
  AST_CMD_AFTER_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> (cke && mem_rst_n && busy)); // R2
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> !cmd_vld); // R3
  AST_MR3_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cmd_type && cmd_ba == 3'd3) |-> (cmd_addr == 13'h000)); // R7
  AST_MR0_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cmd_type && cmd_ba == 3'd0) |-> (cmd_addr == 13'h528)); // R4
  AST_MRS_CS_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cmd_type) |-> cs_mask[cmd_cs]); // R8
  AST_ZQ_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_type) |-> (cmd_addr == 13'h400 && cmd_ba == 3'd0 && cmd_cs <= CS_W'(1))); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done)); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && mem_rst_n) |=> mem_rst_n); // R10
endmodule

bind ddr3_pwrup_seq ddr3_pwrup_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cs_mask(cs_mask),
  .mem_rst_n(mem_rst_n), .cke(cke), .cmd_vld(cmd_vld), .cmd_type(cmd_type),
  .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .cmd_cs(cmd_cs), .busy(busy), .done(done));

// File: tb/sim_ddr3_pwrup_seq.sv
module sim_ddr3_pwrup_seq;
  localparam int CLK_NS = 10;
  localparam int NCS    = 8;
  // hand-computed ceilings for 10 ns clock (R2): 200/10, 500/10, ceil(3.6), ceil(40.5)
  localparam int RC = 20, SC = 50, CC = 4, DC = 41, MC = 4, ZC = 16;

  typedef struct packed {
    int          t;
    logic        typ;
    logic [2:0]  ba;
    logic [12:0] addr;
    logic [2:0]  cs;
  } item_t;

  logic clk = 0, rst_n = 0, start = 0, rdimm = 0;
  logic [NCS-1:0] cs_mask = '0;
  logic [2:0] odt_nom = '0;
  logic [1:0] odt_dyn = '0;
  logic mem_rst_n, cke, cmd_vld, cmd_type, busy, done;
  logic [2:0] cmd_ba, cmd_cs;
  logic [12:0] cmd_addr;

  int total = 0, bad = 0, cyc = 0, t0 = 0;
  int t_rst, t_cke, t_done;
  bit armed = 0, finished = 0;
  logic prev_rst = 0, prev_cke = 0;
  item_t exp_q[$];
  string tag_q[$];

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr3_pwrup_seq #(.CLK_PS(10000), .T_RESET_NS(200), .T_STAB_NS(500), .T_CKE_NS(36),
    .T_DLL_NS(405), .TMRD_CYC(MC), .TZQINIT_CYC(ZC), .NUM_CS(NCS)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cs_mask(cs_mask), .rdimm(rdimm),
    .odt_nom(odt_nom), .odt_dyn(odt_dyn), .mem_rst_n(mem_rst_n), .cke(cke),
    .cmd_vld(cmd_vld), .cmd_type(cmd_type), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr),
    .cmd_cs(cmd_cs), .busy(busy), .done(done));

  task automatic chk(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push(input int t, input logic typ, input logic [2:0] ba,
                      input logic [12:0] a, input logic [2:0] cs, input string tag);
    item_t it;
    it.t = t; it.typ = typ; it.ba = ba; it.addr = a; it.cs = cs;
    exp_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (armed) begin
      if (mem_rst_n && !prev_rst) t_rst = cyc - t0;
      if (cke && !prev_cke) t_cke = cyc - t0;
      if (done) begin
        t_done = cyc - t0;
        chk("R9 busy low at done", int'(busy), 0);
      end
      if (cmd_vld) begin
        if (exp_q.size() == 0) begin
          chk("R3 unexpected command", 1, 0);
        end else begin
          item_t e;
          string tg;
          e = exp_q.pop_front();
          tg = tag_q.pop_front();
          chk({tg, " time"}, cyc - t0, e.t);
          chk({tg, " type"}, int'(cmd_type), int'(e.typ));
          chk({tg, " bank"}, int'(cmd_ba), int'(e.ba));
          chk({tg, " addr"}, int'(cmd_addr), int'(e.addr));
          chk({tg, " cs"}, int'(cmd_cs), int'(e.cs));
        end
      end
    end
    prev_rst = mem_rst_n;
    prev_cke = cke;
  end

  task automatic run(input logic [NCS-1:0] m, input logic rd, input logic [2:0] nom,
                     input logic [1:0] dyn, input bit dup);
    int t;
    logic [12:0] w1, w2;
    @(negedge clk);
    cs_mask = m; rdimm = rd; odt_nom = nom; odt_dyn = dyn;
    w1 = 13'h002 | (13'(nom[0]) << 2) | (13'(nom[1]) << 6) | (13'(nom[2]) << 9);
    w2 = 13'h040 | (13'(dyn) << 9);
    t = RC + SC + CC + 1;
    for (int i = 0; i < NCS; i++) begin
      if (m[i]) begin
        push(t,          1'b0, 3'd2, w2,      3'(i), "R6 MR2 R8");
        push(t + MC,     1'b0, 3'd3, 13'h0,   3'(i), "R7 MR3 R3");
        push(t + 2 * MC, 1'b0, 3'd1, w1,      3'(i), "R5 MR1 R3");
        push(t + 3 * MC, 1'b0, 3'd0, 13'h528, 3'(i), "R4 MR0 R3");
        t = t + 3 * MC + DC + 1;
        if (!rd) break;
      end
    end
    push(t,          1'b1, 3'd0, 13'h400, 3'd0, (m == '0) ? "R11 ZQ even" : "R9 ZQ even");
    push(t + ZC + 1, 1'b1, 3'd0, 13'h400, 3'd1, "R9 ZQ odd");
    t_rst = -1; t_cke = -1; t_done = -1;
    start = 1;
    @(negedge clk);
    start = 0; t0 = cyc; armed = 1;
    chk("R2 busy after start", int'(busy), 1);
    chk("R2 reset held low", int'(mem_rst_n), 0);
    if (dup) begin
      repeat (30) @(negedge clk);
      start = 1;             // R10: ignored while busy
      @(negedge clk);
      start = 0;
    end
    for (int k = 0; k < 3000 && t_done < 0; k++) @(negedge clk);
    chk("R2 reset release time", t_rst, RC);
    chk("R2 cke rise time", t_cke, RC + SC);
    chk("R9 done time", t_done, t + 2 * ZC + 1);
    chk("R3 queue drained", exp_q.size(), 0);
    if (dup) chk("R10 sequence unaffected", int'(busy), 0);
    repeat (2) @(negedge clk);
    chk("R9 done one cycle", int'(done), 0);
    armed = 0;
    exp_q.delete(); tag_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mem_rst_n", int'(mem_rst_n), 0);
    chk("R1 cke", int'(cke), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 cmd_vld", int'(cmd_vld), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run(8'b1010_0100, 1'b1, 3'b101, 2'b10, 1'b1);  // R8 sparse walk, R10
    run(8'b0110_0000, 1'b0, 3'b010, 2'b01, 1'b0);  // R8 unregistered: first only
    run(8'b0000_0000, 1'b1, 3'b000, 2'b00, 1'b0);  // R11 empty mask
    run(8'b1111_1111, 1'b1, 3'b111, 2'b11, 1'b0);  // R8 all present, cs0..cs7
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule